// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block sits beside one processor core and keeps the set of interrupt requests that are waiting for it. Sources raise requests by pulsing their bit on a raise vector; the block holds them in a pending register and, every cycle, picks at most one request to hand to the core. The choice follows a fixed priority chain. Some sources are gated by machine-state bits (external interrupt enable, hypervisor state) or partition-control bits (an external-routing bit and a hypervisor-decrementer enable). When a request is chosen, the block emits a one-cycle take pulse with a 4-bit cause code. It drops the pending bit if that source is edge-like; level-like sources keep their bit until the source withdraws it.

The block also tracks a low-power state. Entering it throws away any pending hypervisor-decrementer request and treats the interrupt-enable bit as set. While the core sleeps, only wake-capable sources can be chosen. Every wakeup except a machine check is reported as a reset cause together with a 4-bit wake-reason code. Any delivery ends the low-power state. Vector address generation and save/restore of machine state belong to the core.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, pend_o is all zero, ps_o is 0, take_o is 0, cause_o is 0, wake_o is 0, wake_code_o is 0 and req_o is 0.
- R2: Cause codes follow priority, lowest code first: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 external, 5 critical external, 6 watchdog, 7 critical doorbell, 8 fixed-interval timer, 9 programmable timer, 10 decrementer, 11 doorbell, 12 hypervisor doorbell, 13 performance monitor, 14 thermal. Raise, clear and pending vectors use the same index for each source. When several eligible bits are pending, the lowest index is delivered.
- R3: The hypervisor decrementer (index 3) is eligible only when hdice_i is 1 and either the effective enable is 1 or hv_i is 0. Its delivery clears its pending bit.
- R4: External (index 4) is eligible when the effective enable is 1, or when HAS_HV is 1, hv_i is 0 and lpes0_i is 0. Critical external (index 5) is always eligible. Delivery clears neither bit.
- R5: Delivery clears the pending bit of indices 0, 1, 2, 6, 7, 8, 9, 11, 12, 13 and 14.
- R6: Delivery of the decrementer (index 10) clears its bit only when dec_clr_i is 1 in the deciding cycle.
- R7: A raise_i bit sets its pending bit at the next edge. It wins over a same-cycle clr_i bit and over clear-on-delivery of any other source. A raise of the bit being delivered in the same cycle is absorbed by that delivery's clear.
- R8: take_o pulses on the edge after the cycle in which an eligible bit is pending, with cause_o for that cycle's choice. With no eligible bit, take_o, cause_o, wake_o and wake_code_o are 0. req_o is 1 exactly when pend_o is nonzero.
- R9: A ps_enter_i pulse sets ps_o at the next edge unless a delivery is decided in that same cycle. It also clears pending index 3, overriding a same-cycle raise. While ps_o is 1 the effective enable is 1 regardless of ee_i.
- R10: While ps_o is 1, only indices 0, 1, 4, 10, 11 and 12 are eligible. A chosen source other than 1 is delivered with cause_o 0, wake_o 1 and wake_code_o of 4 (reset), 8 (external), 6 (decrementer), 5 (doorbell) or 3 (hypervisor doorbell). The original source's own clear rule still applies, and ps_o drops at the same edge.
- R11: A machine check chosen while ps_o is 1 is delivered as cause 1 with wake_o 0 and wake_code_o 0, and ps_o drops.
- R12: A clr_i bit with no same-cycle raise clears that pending bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 15 | Per-source request set pulses |
| clr_i | input | 15 | Per-source request withdraw pulses |
| ee_i | input | 1 | Machine-state external interrupt enable |
| hv_i | input | 1 | Machine-state hypervisor bit |
| lpes0_i | input | 1 | Partition control: externals stay in guest when 1 |
| hdice_i | input | 1 | Partition control: hypervisor decrementer enable |
| dec_clr_i | input | 1 | Decrementer clears on delivery when 1 |
| ps_enter_i | input | 1 | Pulse to enter the low-power state |
| take_o | output | 1 | One-cycle delivery pulse |
| cause_o | output | 4 | Delivered cause code |
| wake_o | output | 1 | Delivery is a redirected wakeup |
| wake_code_o | output | 4 | Wake-reason code, 0 when not a wakeup |
| req_o | output | 1 | Some request is pending |
| ps_o | output | 1 | Low-power state |
| pend_o | output | 15 | Pending request vector |

## Verification
A wrong pending bit shows on pend_o and req_o at the very next edge. It also shows on the following take pulse, as a wrong or missing cause, or as a level source lost or an edge source delivered twice. A stuck or lost low-power flag shows on ps_o at once and, on the next wakeup, as a cause that is not redirected or a missing wake code. The bench therefore compares every output against a behavioural model on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int NSRC = 15;
    localparam int CW   = 4;

    localparam int SRC_RST  = 0;
    localparam int SRC_MCK  = 1;
    localparam int SRC_DBG  = 2;
    localparam int SRC_HDEC = 3;
    localparam int SRC_EXT  = 4;
    localparam int SRC_CEXT = 5;
    localparam int SRC_WDT  = 6;
    localparam int SRC_CDB  = 7;
    localparam int SRC_FIT  = 8;
    localparam int SRC_PIT  = 9;
    localparam int SRC_DEC  = 10;
    localparam int SRC_DB   = 11;
    localparam int SRC_HDB  = 12;
    localparam int SRC_PMU  = 13;
    localparam int SRC_THM  = 14;

    // sources allowed to end the low-power state
    localparam logic [NSRC-1:0] WAKE_MASK =
        NSRC'((1 << SRC_RST) | (1 << SRC_MCK) | (1 << SRC_EXT) |
              (1 << SRC_DEC) | (1 << SRC_DB)  | (1 << SRC_HDB));

    // level-like sources never cleared by delivery
    localparam logic [NSRC-1:0] LEVEL_MASK =
        NSRC'((1 << SRC_EXT) | (1 << SRC_CEXT));

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            ps;
        logic            take;
        logic [CW-1:0]   cause;
        logic            wake;
        logic [CW-1:0]   code;
    } arb_state_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_arb_pkg::*;
#(
    parameter bit HAS_HV = 1'b1
) (
    input  logic [NSRC-1:0] pend,
    input  logic            ee_eff,
    input  logic            hv,
    input  logic            lpes0,
    input  logic            hdice,
    input  logic            ps,
    output logic [NSRC-1:0] elig
);
    logic [NSRC-1:0] gate;

    always_comb begin
        gate           = '1;
        gate[SRC_HDEC] = hdice & (ee_eff | ~hv);
        gate[SRC_EXT]  = ee_eff | (HAS_HV & ~hv & ~lpes0);
        if (ps) begin
            gate = gate & WAKE_MASK;
        end
        elig = pend & gate;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
(
    input  logic [NSRC-1:0] elig,
    output logic            any,
    output logic [NSRC-1:0] grant,
    output logic [CW-1:0]   idx
);
    logic [NSRC-1:0] above;

    assign above[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < NSRC; g++) begin : g_chain
            assign above[g] = above[g-1] | elig[g-1];
        end
    endgenerate

    assign grant = elig & ~above;
    assign any   = |elig;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/irq_wake_code.sv
module irq_wake_code
    import irq_arb_pkg::*;
(
    input  logic [CW-1:0] idx,
    output logic [CW-1:0] code
);
    always_comb begin
        case (int'(idx))
            SRC_RST: code = 4'h4;
            SRC_EXT: code = 4'h8;
            SRC_DEC: code = 4'h6;
            SRC_DB:  code = 4'h5;
            SRC_HDB: code = 4'h3;
            default: code = 4'h0;
        endcase
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter bit HAS_HV = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raise_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            ee_i,
    input  logic            hv_i,
    input  logic            lpes0_i,
    input  logic            hdice_i,
    input  logic            dec_clr_i,
    input  logic            ps_enter_i,
    output logic            take_o,
    output logic [CW-1:0]   cause_o,
    output logic            wake_o,
    output logic [CW-1:0]   wake_code_o,
    output logic            req_o,
    output logic            ps_o,
    output logic [NSRC-1:0] pend_o
);
    arb_state_t state_d, state_q;

    logic [NSRC-1:0] elig, grant, clr_rule, deliver_clr;
    logic            any;
    logic [CW-1:0]   idx, wcode;
    logic            is_mck;

    irq_gate #(.HAS_HV(HAS_HV)) u_gate (
        .pend   (state_q.pend),
        .ee_eff (ee_i | state_q.ps),
        .hv     (hv_i),
        .lpes0  (lpes0_i),
        .hdice  (hdice_i),
        .ps     (state_q.ps),
        .elig   (elig)
    );

    irq_pick u_pick (
        .elig  (elig),
        .any   (any),
        .grant (grant),
        .idx   (idx)
    );

    irq_wake_code u_wcode (
        .idx  (idx),
        .code (wcode)
    );

    assign is_mck = (int'(idx) == SRC_MCK);

    always_comb begin
        clr_rule          = ~LEVEL_MASK;
        clr_rule[SRC_DEC] = dec_clr_i;
        deliver_clr       = grant & clr_rule;

        state_d = state_q;
        state_d.pend = ((state_q.pend & ~clr_i) | raise_i) & ~deliver_clr;
        if (ps_enter_i) begin
            state_d.pend[SRC_HDEC] = 1'b0;
        end

        state_d.take  = any;
        state_d.wake  = any & state_q.ps & ~is_mck;
        state_d.cause = '0;
        state_d.code  = '0;
        if (any) begin
            state_d.cause = state_d.wake ? CW'(SRC_RST) : idx;
            state_d.code  = state_d.wake ? wcode : '0;
        end

        state_d.ps = any ? 1'b0 : (state_q.ps | ps_enter_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign take_o      = state_q.take;
    assign cause_o     = state_q.cause;
    assign wake_o      = state_q.wake;
    assign wake_code_o = state_q.code;
    assign req_o       = |state_q.pend;
    assign ps_o        = state_q.ps;
    assign pend_o      = state_q.pend;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
    import irq_arb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] clr_i,
    input logic            ps_enter_i,
    input logic            take_o,
    input logic [CW-1:0]   cause_o,
    input logic            wake_o,
    input logic [CW-1:0]   wake_code_o,
    input logic            req_o,
    input logic            ps_o,
    input logic [NSRC-1:0] pend_o
);
    p_cause_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cause_o < CW'(NSRC)));

    p_no_take_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_o |=> !take_o);

    p_quiet_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0 && !wake_o && wake_code_o == '0));

    p_wake_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (take_o && cause_o == '0 && !ps_o && wake_code_o != '0));

    p_hdec_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ps_enter_i |=> !pend_o[SRC_HDEC]);

    p_mck_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == CW'(SRC_MCK)) |-> !pend_o[SRC_MCK]);

    p_mck_no_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == CW'(SRC_MCK)) |-> (!wake_o && !ps_o));

    p_ext_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == CW'(SRC_EXT) && !$past(clr_i[SRC_EXT]))
            |-> pend_o[SRC_EXT]);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .ps_enter_i  (ps_enter_i),
    .take_o      (take_o),
    .cause_o     (cause_o),
    .wake_o      (wake_o),
    .wake_code_o (wake_code_o),
    .req_o       (req_o),
    .ps_o        (ps_o),
    .pend_o      (pend_o)
);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
    localparam int N = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] raise = '0, clr = '0;
    logic ee = 0, hv = 0, lpes0 = 0, hdice = 0, dec_clr = 0, ps_enter = 0;

    logic         take, wake, req, ps;
    logic [3:0]   cause, wcode;
    logic [N-1:0] pend;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .raise_i(raise), .clr_i(clr),
        .ee_i(ee), .hv_i(hv), .lpes0_i(lpes0), .hdice_i(hdice),
        .dec_clr_i(dec_clr), .ps_enter_i(ps_enter),
        .take_o(take), .cause_o(cause), .wake_o(wake),
        .wake_code_o(wcode), .req_o(req), .ps_o(ps), .pend_o(pend)
    );

    // behavioural reference
    logic [N-1:0] m_pend = '0;
    bit m_ps = 0, m_take = 0, m_wake = 0;
    int m_cause = 0, m_code = 0;

    function automatic bit may_wake(int s);
        return (s == 0 || s == 1 || s == 4 || s == 10 || s == 11 || s == 12);
    endfunction

    function automatic bit eligible(int s, bit ee_e, bit in_ps);
        if (in_ps && !may_wake(s)) return 0;
        if (s == 3) return hdice && (ee_e || !hv);
        if (s == 4) return ee_e || (!hv && !lpes0);
        return 1;
    endfunction

    function automatic bit clears(int s);
        if (s == 4 || s == 5) return 0;
        if (s == 10) return dec_clr;
        return 1;
    endfunction

    function automatic int reason(int s);
        case (s)
            0: return 4;
            4: return 8;
            10: return 6;
            11: return 5;
            12: return 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_ps = 0; m_take = 0; m_wake = 0; m_cause = 0; m_code = 0;
        end else begin
            automatic int win = -1;
            automatic bit ee_e = ee || m_ps;
            automatic logic [N-1:0] np;
            for (int s = 0; s < N; s++)
                if (win < 0 && m_pend[s] && eligible(s, ee_e, m_ps)) win = s;
            for (int s = 0; s < N; s++) begin
                np[s] = (m_pend[s] && !clr[s]) || raise[s];
                if (s == win && clears(s)) np[s] = 0;
            end
            if (ps_enter) np[3] = 0;
            m_take = (win >= 0);
            m_wake = m_take && m_ps && win != 1;
            m_cause = !m_take ? 0 : (m_wake ? 0 : win);
            m_code = m_wake ? reason(win) : 0;
            m_ps = m_take ? 0 : (m_ps || ps_enter);
            m_pend = np;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (take !== m_take || cause !== 4'(m_cause) || wake !== m_wake ||
                wcode !== 4'(m_code) || req !== (|m_pend) || ps !== m_ps ||
                pend !== m_pend) begin
                errors++;
                $display("FAIL %s t=%0t act take=%b cause=%0d wake=%b code=%0d req=%b ps=%b pend=%h exp take=%b cause=%0d wake=%b code=%0d req=%b ps=%b pend=%h",
                    tag, $time, take, cause, wake, wcode, req, ps, pend,
                    m_take, m_cause, m_wake, m_code, |m_pend, m_ps, m_pend);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_raise(logic [N-1:0] v);
        raise = v; step(1); raise = '0;
    endtask

    task automatic pulse_clr(logic [N-1:0] v);
        clr = v; step(1); clr = '0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired in %s", tag);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        tag = "R1";
        if (take !== 0 || pend !== '0 || req !== 0 || ps !== 0) begin
            errors++;
            $display("FAIL R1 reset act take=%b pend=%h ps=%b exp 0 0 0", take, pend, ps);
        end
        checks++;
        rst_n = 1; step(2);

        // R2 / R5: all sources, externals and hdec gated off
        tag = "R2"; ee = 0; hv = 1; hdice = 0; dec_clr = 1;
        pulse_raise('1); step(6);
        tag = "R5"; pulse_clr(15'(1 << 5)); step(14);

        // R3: hypervisor decrementer gating
        tag = "R3"; hdice = 1; step(2); hdice = 0; pulse_raise(15'(1 << 3)); step(2);
        hv = 0; step(1); hdice = 1; step(3);

        // R4: external level behaviour and routing bit
        tag = "R4"; hv = 0; lpes0 = 1; step(2); lpes0 = 0; step(3);
        ee = 1; hv = 1; step(2); ee = 0; step(2);
        pulse_clr(15'(1 << 4)); step(2);
        pulse_raise(15'(1 << 5)); step(3); pulse_clr(15'(1 << 5)); step(2);

        // R6: decrementer clear option
        tag = "R6"; dec_clr = 0; pulse_raise(15'(1 << 10)); step(3);
        dec_clr = 1; step(3);

        // R7 / R12: set versus clear precedence
        tag = "R7"; raise = 15'(1 << 14); clr = 15'(1 << 14); step(1);
        raise = 15'h0104; step(1); raise = '0; clr = '0; step(1);
        raise = 15'(1 << 6); step(1); raise = '0; step(4);
        tag = "R12"; hdice = 0; pulse_raise(15'(1 << 3)); pulse_clr(15'(1 << 3)); step(2);

        // R8: idle gives no pulse
        tag = "R8"; ee = 0; hv = 1; step(4);

        // R9 / R10: low-power entry and wakeups
        tag = "R9"; pulse_raise(15'(1 << 3)); ps_enter = 1; raise = 15'(1 << 3); step(1);
        ps_enter = 0; raise = '0; step(2);
        pulse_raise(15'(1 << 14) | 15'(1 << 6)); step(3);
        tag = "R10"; pulse_raise(15'(1 << 10)); step(3);
        pulse_clr('1); step(2);
        ps_enter = 1; step(1); ps_enter = 0; pulse_raise(15'(1 << 4)); step(3);
        pulse_clr(15'(1 << 4)); ee = 0; hv = 1; step(1);
        ps_enter = 1; step(1); ps_enter = 0; pulse_raise(15'(1 << 12)); step(3);
        ps_enter = 1; step(1); ps_enter = 0; pulse_raise(15'(1 << 11)); step(3);
        ps_enter = 1; step(1); ps_enter = 0; pulse_raise(15'(1 << 0)); step(3);
        tag = "R11"; ps_enter = 1; step(1); ps_enter = 0;
        pulse_raise(15'(1 << 1) | 15'(1 << 12)); step(4);
        pulse_clr('1); step(2);

        // mixed traffic
        tag = "R7";
        for (int k = 0; k < 400; k++) begin
            raise = 15'($urandom) & 15'($urandom) & 15'($urandom);
            clr = 15'($urandom) & 15'($urandom);
            ee = 1'($urandom); hv = 1'($urandom); lpes0 = 1'($urandom);
            hdice = 1'($urandom); dec_clr = 1'($urandom);
            ps_enter = (($urandom % 8) == 0);
            step(1);
        end
        raise = '0; clr = '1; ps_enter = 0; step(2); clr = '0; step(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule